// File: doc/BRIEF.md
# Serial Engine Run-State Controller

This block is the control and status register file that sits in front of a serial master engine. Software reaches it through a narrow single-cycle register port and uses it to move the engine between three operating states (reset, run and pause). A state change is posted. The controller then holds off for a fixed settling window, and during that window it reports the state as unsettled. Only after the window has ended does the new state appear on the read port and on the state output that drives the engine.

Around the state machine the block gathers status from the engine into sticky flags that software clears by writing ones. These are FIFO occupancy indications, service requests, done pulses, core error pulses and bus error pulses. A mask register selects which error and service flags raise the level-sensitive interrupt. A software reset register returns the state to reset, presets the operational flags and wipes the error records. Bus errors can also be cleared by moving the engine back to the reset state.

Top module: `rsc_ctl`

## Requirements
- R1: After reset the state register (address 0) reads 0x4 with the master-ready input low: the state code in bits 1:0 is 0 (reset), and bit 2 (settled) is 1. The other state codes are 1 (run) and 3 (pause).
- R2: A write to address 0 that is accepted drives bit 2 low for exactly SETTLE cycles (6 by default). During those cycles bits 1:0 and the `eng_state` output keep the old code. In the next cycle the new code appears with bit 2 high.
- R3: A write to address 0 is ignored when bit 2 is 0 or when it carries code 2. Such a write sets the sticky bit 5 of address 0. Only a software reset clears that bit.
- R4: Bit 4 of address 0 follows the `eng_master_ok` input.
- R5: Address 1 holds eight sticky flags in bits 11:4. Bit 4 is out-not-empty, bit 5 in-not-empty and bit 6 out-full; each is set in every cycle its level input is high. Bit 7 has no source. Bit 8 is the out-service pulse, bit 9 the in-service pulse, bit 10 out-done and bit 11 in-done. Writing 1 to a bit clears it, but a set in the same cycle wins.
- R6: Address 2 bits 6:2 record core error pulses, with input bit i landing in bit 2+i. Writing 1 clears a bit, and a set in the same cycle wins.
- R7: Address 4 bits 2:0 record bus error pulses. They are cleared only by an accepted write of code 0 to address 0 or by a software reset. A write of code 0 that is ignored leaves them unchanged.
- R8: Writing a value with bit 0 set to address 5 is a software reset. It sets the state code to 0 at once and starts a settling window. It sets address 1 to 0xFF0, clears addresses 2 and 4 and the bit 5 of address 0, and leaves address 3 unchanged. Writing 0 to address 5 has no effect.
- R9: Address 3 is the interrupt enable register, reset to 0. Bits 6:2 enable the core errors, bits 9:8 the two service flags and bits 14:12 the bus errors. All other bits read 0. `irq` is high exactly when some flag is set and its enable bit is 1.
- R10: Address 5 and addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register word address for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| eng_out_nempty | input | 1 | Engine output queue holds data (level) |
| eng_in_nempty | input | 1 | Engine input queue holds data (level) |
| eng_out_full | input | 1 | Engine output queue full (level) |
| eng_out_svc | input | 1 | Output service request pulse |
| eng_in_svc | input | 1 | Input service request pulse |
| eng_out_done | input | 1 | Output count reached pulse |
| eng_in_done | input | 1 | Input count reached pulse |
| eng_core_err | input | 5 | Core error pulses |
| eng_bus_err | input | 3 | Bus protocol error pulses |
| eng_master_ok | input | 1 | Engine ready to act as bus master (level) |
| eng_state | output | 2 | Settled operating state code to the engine |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the edges of the settling window. It writes again while the window is still open, which a design without the hold-off would accept, so the state would jump early and no illegal bit would be set. It counts the unsettled cycles one by one, so a counter that is off by one shows up as a valid bit that rises a cycle early or late. It also clears a flag in the same cycle its source fires; a design that lets the clear win would lose that event. Bus errors are checked against a reset-code write that is ignored, which a careless design would still let clear the record. A long stretch with random traffic, including software resets, is compared cycle by cycle with a behavioural model.

// File: rtl/rsc_pkg.sv
`timescale 1ns/1ps
package rsc_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd3
    } run_state_e;

    // register word addresses
    localparam logic [ADDR_W-1:0] RA_STATE = 3'd0;
    localparam logic [ADDR_W-1:0] RA_OPER  = 3'd1;
    localparam logic [ADDR_W-1:0] RA_CERR  = 3'd2;
    localparam logic [ADDR_W-1:0] RA_IRQEN = 3'd3;
    localparam logic [ADDR_W-1:0] RA_BERR  = 3'd4;
    localparam logic [ADDR_W-1:0] RA_SWRST = 3'd5;

    // bit positions inside the state register
    localparam int VALID_BIT = 2;
    localparam int MST_BIT   = 4;
    localparam int ILL_BIT   = 5;

    // field positions shared by flag and enable registers
    localparam int OPER_LSB = 4;
    localparam int OPER_W   = 8;
    localparam int CERR_LSB = 2;
    localparam int SVC_LSB  = 8;
    localparam int BERR_LSB = 12;

    typedef struct packed {
        logic                  wr;
        logic [ADDR_W-1:0]     addr;
        logic [31:0]           data;
    } bus_req_t;

    function automatic logic code_legal(input logic [1:0] code);
        return code != 2'd2;
    endfunction

endpackage

// File: rtl/rsc_state_ctl.sv
`timescale 1ns/1ps
module rsc_state_ctl
    import rsc_pkg::*;
#(
    parameter int SETTLE = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_wr,
    input  logic [1:0] req_code,
    input  logic       force_rst,
    output run_state_e cur_state,
    output logic       valid,
    output logic       illegal,
    output logic       accept
);
    localparam int CNT_W = $clog2(SETTLE + 1);

    logic [CNT_W-1:0] cnt;
    run_state_e       pend;

    assign valid  = (cnt == '0);
    assign accept = req_wr && valid && code_legal(req_code) && !force_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            cur_state <= ST_RESET;
            pend      <= ST_RESET;
            illegal   <= 1'b0;
        end else if (force_rst) begin
            cnt       <= CNT_W'(SETTLE);
            cur_state <= ST_RESET;
            pend      <= ST_RESET;
            illegal   <= 1'b0;
        end else if (accept) begin
            pend <= run_state_e'(req_code);
            cnt  <= CNT_W'(SETTLE);
        end else begin
            if (req_wr)
                illegal <= 1'b1;
            if (cnt != '0) begin
                cnt <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1))
                    cur_state <= pend;
            end
        end
    end

endmodule

// File: rtl/rsc_flag_bank.sv
`timescale 1ns/1ps
module rsc_flag_bank #(
    parameter int           W      = 8,
    parameter logic [W-1:0] PRESET = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bulk_clr,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] w1c_vec,
    output logic [W-1:0] flags
);
    always_ff @(posedge clk) begin
        if (rst || bulk_clr)
            flags <= PRESET;
        else
            flags <= (flags & ~w1c_vec) | set_vec;
    end
endmodule

// File: rtl/rsc_irq_merge.sv
`timescale 1ns/1ps
module rsc_irq_merge #(
    parameter int CERR_W = 5,
    parameter int BERR_W = 3
) (
    input  logic [CERR_W-1:0] cerr,
    input  logic [CERR_W-1:0] cerr_en,
    input  logic [1:0]        svc,
    input  logic [1:0]        svc_en,
    input  logic [BERR_W-1:0] berr,
    input  logic [BERR_W-1:0] berr_en,
    output logic              irq
);
    localparam int N = CERR_W + 2 + BERR_W;

    logic [N-1:0] src;
    logic [N-1:0] msk;

    assign src = {berr, svc, cerr};
    assign msk = {berr_en, svc_en, cerr_en};

    logic [N-1:0] hit;
    for (genvar i = 0; i < N; i++) begin : g_hit
        assign hit[i] = src[i] & msk[i];
    end

    assign irq = |hit;
endmodule

// File: rtl/rsc_ctl.sv
`timescale 1ns/1ps
module rsc_ctl
    import rsc_pkg::*;
#(
    parameter int SETTLE = 6,
    parameter int DATA_W = 32,
    parameter int CERR_W = 5,
    parameter int BERR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_out_nempty,
    input  logic              eng_in_nempty,
    input  logic              eng_out_full,
    input  logic              eng_out_svc,
    input  logic              eng_in_svc,
    input  logic              eng_out_done,
    input  logic              eng_in_done,
    input  logic [CERR_W-1:0] eng_core_err,
    input  logic [BERR_W-1:0] eng_bus_err,
    input  logic              eng_master_ok,
    output logic [1:0]        eng_state,
    output logic              irq
);
    localparam logic [DATA_W-1:0] EN_MASK =
        (((DATA_W'(1) << CERR_W) - DATA_W'(1)) << CERR_LSB) |
        (DATA_W'(3) << SVC_LSB) |
        (((DATA_W'(1) << BERR_W) - DATA_W'(1)) << BERR_LSB);

    bus_req_t req;
    assign req.wr   = bus_wr;
    assign req.addr = bus_addr;
    assign req.data = 32'(bus_wdata);

    logic wr_state, wr_oper, wr_cerr, wr_en, swr;
    assign wr_state = req.wr && (req.addr == RA_STATE);
    assign wr_oper  = req.wr && (req.addr == RA_OPER);
    assign wr_cerr  = req.wr && (req.addr == RA_CERR);
    assign wr_en    = req.wr && (req.addr == RA_IRQEN);
    assign swr      = req.wr && (req.addr == RA_SWRST) && req.data[0];

    // operating state and settling window
    run_state_e cur_state;
    logic       st_valid, st_illegal, st_accept;

    rsc_state_ctl #(.SETTLE(SETTLE)) u_state (
        .clk       (clk),
        .rst       (rst),
        .req_wr    (wr_state),
        .req_code  (req.data[1:0]),
        .force_rst (swr),
        .cur_state (cur_state),
        .valid     (st_valid),
        .illegal   (st_illegal),
        .accept    (st_accept)
    );

    assign eng_state = cur_state;

    // operational flags, bits 11:4 of their register
    logic [OPER_W-1:0] oper_set, oper_clr, oper_q;
    assign oper_set = {eng_in_done, eng_out_done, eng_in_svc, eng_out_svc,
                       1'b0, eng_out_full, eng_in_nempty, eng_out_nempty};
    assign oper_clr = wr_oper ? req.data[OPER_LSB +: OPER_W] : '0;

    rsc_flag_bank #(.W(OPER_W), .PRESET({OPER_W{1'b1}})) u_oper (
        .clk      (clk),
        .rst      (rst),
        .bulk_clr (swr),
        .set_vec  (oper_set),
        .w1c_vec  (oper_clr),
        .flags    (oper_q)
    );

    // core error flags
    logic [CERR_W-1:0] cerr_clr, cerr_q;
    assign cerr_clr = wr_cerr ? req.data[CERR_LSB +: CERR_W] : '0;

    rsc_flag_bank #(.W(CERR_W), .PRESET('0)) u_cerr (
        .clk      (clk),
        .rst      (rst),
        .bulk_clr (swr),
        .set_vec  (eng_core_err),
        .w1c_vec  (cerr_clr),
        .flags    (cerr_q)
    );

    // bus error flags: wiped by a reset-code transition
    logic berr_wipe;
    logic [BERR_W-1:0] berr_q;
    assign berr_wipe = swr || (st_accept && req.data[1:0] == ST_RESET);

    rsc_flag_bank #(.W(BERR_W), .PRESET('0)) u_berr (
        .clk      (clk),
        .rst      (rst),
        .bulk_clr (berr_wipe),
        .set_vec  (eng_bus_err),
        .w1c_vec  ('0),
        .flags    (berr_q)
    );

    // interrupt enables
    logic [DATA_W-1:0] en_q;
    logic              en_any;
    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (wr_en)
            en_q <= bus_wdata & EN_MASK;
    end
    assign en_any = |en_q;

    rsc_irq_merge #(.CERR_W(CERR_W), .BERR_W(BERR_W)) u_irq (
        .cerr    (cerr_q),
        .cerr_en (en_q[CERR_LSB +: CERR_W]),
        .svc     (oper_q[SVC_LSB-OPER_LSB +: 2]),
        .svc_en  (en_q[SVC_LSB +: 2]),
        .berr    (berr_q),
        .berr_en (en_q[BERR_LSB +: BERR_W]),
        .irq     (irq)
    );

    // read port
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_STATE: begin
                bus_rdata[1:0]       = cur_state;
                bus_rdata[VALID_BIT] = st_valid;
                bus_rdata[MST_BIT]   = eng_master_ok;
                bus_rdata[ILL_BIT]   = st_illegal;
            end
            RA_OPER:  bus_rdata[OPER_LSB +: OPER_W] = oper_q;
            RA_CERR:  bus_rdata[CERR_LSB +: CERR_W] = cerr_q;
            RA_IRQEN: bus_rdata = en_q;
            RA_BERR:  bus_rdata[BERR_W-1:0] = berr_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rsc_ctl_chk.sv
`timescale 1ns/1ps
module rsc_ctl_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [1:0]  eng_state,
    input logic        irq,
    input logic        st_valid,
    input logic        st_illegal,
    input logic        en_any
);
    logic swr, st_wr;
    assign swr   = bus_wr && bus_addr == 3'd5 && bus_wdata[0];
    assign st_wr = bus_wr && bus_addr == 3'd0;

    assert_window_opens_R2: assert property (@(posedge clk) disable iff (rst)
        (st_wr && st_valid && bus_wdata[1:0] != 2'd2) |=> !st_valid);

    assert_state_held_R2: assert property (@(posedge clk) disable iff (rst)
        (!st_valid && !swr) |=> (st_valid || $stable(eng_state)));

    assert_busy_write_flagged_R3: assert property (@(posedge clk) disable iff (rst)
        (st_wr && !st_valid && !swr) |=> st_illegal);

    assert_bad_code_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (st_wr && st_valid && bus_wdata[1:0] == 2'd2) |=> ($stable(eng_state) && st_valid && st_illegal));

    assert_illegal_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (st_illegal && !swr) |=> st_illegal);

    assert_soft_reset_R8: assert property (@(posedge clk) disable iff (rst)
        swr |=> (eng_state == 2'd0 && !st_valid && !st_illegal));

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
        !en_any |-> !irq);
endmodule

bind rsc_ctl rsc_ctl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .eng_state  (eng_state),
    .irq        (irq),
    .st_valid   (st_valid),
    .st_illegal (st_illegal),
    .en_any     (en_any)
);

// File: tb/rsc_ctl_bench.sv
`timescale 1ns/1ps
module rsc_ctl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        b_wr = 1'b0;
    logic [2:0]  b_addr = 3'd0;
    logic [31:0] b_wd = '0;
    logic [31:0] bus_rdata;
    logic        s_out_ne = 0, s_in_ne = 0, s_out_full = 0;
    logic        s_out_svc = 0, s_in_svc = 0, s_out_done = 0, s_in_done = 0;
    logic [4:0]  s_cerr = '0;
    logic [2:0]  s_berr = '0;
    logic        s_mst = 1'b0;
    logic [1:0]  eng_state;
    logic        irq;

    always #2.5 clk = ~clk;

    rsc_ctl u_rsc_ctl (
        .clk            (clk),
        .rst            (rst),
        .bus_wr         (b_wr),
        .bus_addr       (b_addr),
        .bus_wdata      (b_wd),
        .bus_rdata      (bus_rdata),
        .eng_out_nempty (s_out_ne),
        .eng_in_nempty  (s_in_ne),
        .eng_out_full   (s_out_full),
        .eng_out_svc    (s_out_svc),
        .eng_in_svc     (s_in_svc),
        .eng_out_done   (s_out_done),
        .eng_in_done    (s_in_done),
        .eng_core_err   (s_cerr),
        .eng_bus_err    (s_berr),
        .eng_master_ok  (s_mst),
        .eng_state      (eng_state),
        .irq            (irq)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_state, m_pend, m_cnt, m_ill, m_oper, m_cerr, m_berr, m_en;
    localparam int EN_MASK = 32'h0000_737C;

    function automatic logic [31:0] m_read(input int a);
        case (a)
            0: return 32'(m_state | ((m_cnt == 0) ? 4 : 0) | (s_mst ? 16 : 0) | (m_ill << 5));
            1: return 32'(m_oper << 4);
            2: return 32'(m_cerr << 2);
            3: return 32'(m_en);
            4: return 32'(m_berr);
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic m_irq();
        return ((m_cerr & (m_en >> 2) & 31) != 0) ||
               (((m_oper >> 4) & (m_en >> 8) & 3) != 0) ||
               ((m_berr & (m_en >> 12) & 7) != 0);
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0: return "R1";
            1: return "R5";
            2: return "R6";
            3: return "R9";
            4: return "R7";
            default: return "R10";
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            m_state = 0; m_pend = 0; m_cnt = 0; m_ill = 0;
            m_oper = 8'hFF; m_cerr = 0; m_berr = 0; m_en = 0;
        end else begin
            // compare current outputs with the model
            chk(eng_state == 2'(m_state), "R2 eng_state", 32'(eng_state), 32'(m_state));
            chk(irq == m_irq(), "R9 irq", 32'(irq), 32'(m_irq()));
            chk(bus_rdata == m_read(int'(b_addr)), tag_of(int'(b_addr)), bus_rdata, m_read(int'(b_addr)));
            // advance the model with the inputs seen by the next edge
            begin
                int  set_o;
                bit  swr, acc, st_wr;
                int  code;
                code  = int'(b_wd[1:0]);
                swr   = b_wr && b_addr == 5 && b_wd[0];
                st_wr = b_wr && b_addr == 0;
                acc   = st_wr && m_cnt == 0 && code != 2;
                set_o = {s_in_done, s_out_done, s_in_svc, s_out_svc, 1'b0, s_out_full, s_in_ne, s_out_ne};
                if (swr) begin
                    m_state = 0; m_pend = 0; m_cnt = 6; m_ill = 0;
                    m_oper = 8'hFF; m_cerr = 0; m_berr = 0;
                end else begin
                    m_oper = (m_oper & ~((b_wr && b_addr == 1) ? int'(b_wd[11:4]) : 0)) | set_o;
                    m_cerr = (m_cerr & ~((b_wr && b_addr == 2) ? int'(b_wd[6:2]) : 0)) | int'(s_cerr);
                    if (acc && code == 0) m_berr = 0;
                    else m_berr = m_berr | int'(s_berr);
                    if (acc) begin
                        m_pend = code; m_cnt = 6;
                    end else begin
                        if (st_wr) m_ill = 1;
                        if (m_cnt > 0) begin
                            if (m_cnt == 1) m_state = m_pend;
                            m_cnt--;
                        end
                    end
                end
                if (b_wr && b_addr == 3) m_en = int'(b_wd) & EN_MASK;
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        b_wr = 1'b1; b_addr = a; b_wd = d;
        step();
        b_wr = 1'b0;
    endtask

    task automatic exp_rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        b_addr = a;
        @(negedge clk);
        chk(bus_rdata === exp, tag, bus_rdata, exp);
        step();
    endtask

    task automatic exp_irq(input logic exp, input string tag);
        @(negedge clk);
        chk(irq === exp, tag, 32'(irq), 32'(exp));
        step();
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;

        // R1, R10: reset values
        exp_rd(3'd0, 32'h4, "R1 reset state");
        exp_rd(3'd1, 32'hFF0, "R10 reset oper");
        exp_rd(3'd5, 32'h0, "R10 swrst reads 0");
        exp_irq(1'b0, "R9 reset irq");

        // R4
        s_mst = 1'b1;
        exp_rd(3'd0, 32'h14, "R4 master ready");

        // R2: window length
        wr(3'd0, 32'h1);
        for (int i = 0; i < 6; i++) exp_rd(3'd0, 32'h10, "R2 unsettled");
        exp_rd(3'd0, 32'h15, "R2 settled run");

        // R3: write inside window
        wr(3'd0, 32'h3);
        wr(3'd0, 32'h1);
        repeat (8) step();
        exp_rd(3'd0, 32'h37, "R3 busy write ignored");

        // R8 soft reset
        wr(3'd5, 32'h1);
        exp_rd(3'd0, 32'h10, "R8 soft reset state");
        exp_rd(3'd1, 32'hFF0, "R8 soft reset oper");
        repeat (6) step();
        wr(3'd0, 32'h2);
        exp_rd(3'd0, 32'h34, "R3 code 2 ignored");
        wr(3'd5, 32'h0);
        exp_rd(3'd0, 32'h34, "R8 zero write no effect");

        // R5 operational flags
        wr(3'd1, 32'hFF0);
        exp_rd(3'd1, 32'h0, "R5 clear all");
        s_out_svc = 1'b1; step(); s_out_svc = 1'b0;
        exp_rd(3'd1, 32'h100, "R5 out service");
        s_out_ne = 1'b1; step();
        wr(3'd1, 32'h10);
        exp_rd(3'd1, 32'h110, "R5 set beats clear");
        s_out_ne = 1'b0;
        wr(3'd1, 32'h10);
        exp_rd(3'd1, 32'h100, "R5 level cleared");
        s_in_done = 1'b1; step(); s_in_done = 1'b0;
        exp_rd(3'd1, 32'h900, "R5 in done");

        // R6 core errors
        s_cerr = 5'b00010; step(); s_cerr = '0;
        exp_rd(3'd2, 32'h8, "R6 core error bit");
        wr(3'd2, 32'h8);
        exp_rd(3'd2, 32'h0, "R6 core error cleared");

        // R9 interrupt masking
        exp_irq(1'b0, "R9 masked service");
        wr(3'd3, 32'h100);
        exp_irq(1'b1, "R9 enabled service");
        wr(3'd1, 32'h100);
        exp_irq(1'b0, "R9 service cleared");
        wr(3'd3, 32'h3);
        exp_rd(3'd3, 32'h0, "R9 unused enable bits");

        // R7 bus errors
        s_berr = 3'b001; step(); s_berr = '0;
        exp_rd(3'd4, 32'h1, "R7 bus error set");
        wr(3'd3, 32'h1000);
        exp_irq(1'b1, "R9 bus error irq");
        wr(3'd0, 32'h1);
        wr(3'd0, 32'h0);
        exp_rd(3'd4, 32'h1, "R7 ignored reset write");
        repeat (7) step();
        wr(3'd0, 32'h0);
        exp_rd(3'd4, 32'h0, "R7 reset write clears");
        exp_irq(1'b0, "R9 bus error gone");

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            b_wr       = ($urandom % 4) == 0;
            b_addr     = 3'($urandom % 8);
            b_wd       = $urandom;
            if (b_addr == 3'd5 && ($urandom % 4) != 0) b_wd[0] = 1'b0;
            s_out_ne   = $urandom % 2;
            s_in_ne    = ($urandom % 3) == 0;
            s_out_full = ($urandom % 5) == 0;
            s_out_svc  = ($urandom % 7) == 0;
            s_in_svc   = ($urandom % 7) == 0;
            s_out_done = ($urandom % 9) == 0;
            s_in_done  = ($urandom % 9) == 0;
            s_cerr     = (($urandom % 6) == 0) ? 5'($urandom) : 5'd0;
            s_berr     = (($urandom % 8) == 0) ? 3'($urandom) : 3'd0;
            s_mst      = ($urandom % 10) != 0;
            step();
        end
        b_wr = 1'b0;
        step();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not end)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule